// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a clocked, device-side model of the command front end of a 256K x16 NOR flash. Each clock edge samples chip enable, write enable, output enable, an 18-bit word address and a 16-bit data bus, all active-low strobes. The block recognises write cycles on that bus and steps through protected command sequences. Every sequence except one starts with a fixed two-write unlock, and any write that does not fit the current step throws the sequence away.

An accepted program or erase starts an internal operation. For its duration the block holds a busy state whose length is set by a parameter in clock cycles, and it ignores every write. During that time reads return a status word instead of array data. The behavioural storage is kept small by parameter, but it decodes sectors (2K words) and blocks (32K words) on the full address. Addresses outside the stored range read as all ones, and a program to such an address is discarded. Programming can only clear bits, and erasing sets a whole region to FFFFh.

Top module: `flashCmdFront`

## Requirements
- R1: A write cycle is the interval in which chip enable and write enable are both low while output enable is high. Its address is the one sampled in the first cycle of the interval. Its data is the one sampled in the last cycle before either strobe rises. If output enable goes low during the interval, the write is discarded and the sequence state is kept.
- R2: Programming takes four writes: AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h, then the target address and data. The addressed word becomes its old value ANDed with the data, so a program can only clear bits.
- R3: A program stays busy for PROG_CYC clock cycles, counted from the edge that sees its fourth write end. An erase stays busy for the larger of ERASE_CYC and the stored depth plus one. Array data is returned in the first cycle after busy ends.
- R4: While busy, a read returns a status word. Bit 7 is the complement of data bit 7 of the word being programmed, or 0 during an erase. Bit 6 flips after every completed read access. All other bits are 0.
- R5: While busy, every write is ignored, including ID entry and the exit command.
- R6: Sector erase takes six writes: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, then 30h to any address in the sector. Every word whose address bits 17:11 match is set to FFFFh, and other words keep their value.
- R7: Block erase has the same six-write form with 50h in the last write. It sets every word whose address bits 17:15 match to FFFFh and leaves other blocks unchanged.
- R8: Chip erase has the same form with 10h written to 5555h in the last write, and sets every stored word to FFFFh.
- R9: Any write that does not match the expected step resets the sequence and returns reads to the array. This includes wrong data, a wrong address, or a first write that opens no sequence.
- R10: Unlock followed by 90h to 5555h enters ID mode. In ID mode, address 0 reads 00BFh, address 1 reads 272Eh and any other address reads 0000h. Unlock followed by F0h to 5555h returns to array reads.
- R11: Query mode is entered either by unlock followed by 98h to 5555h, or by a single write of 98h to 0055h. In query mode, addresses 10h, 11h and 12h read 0051h, 0052h and 0059h, and other addresses read 0000h. The F0h exit sequence returns to array reads.
- R12: Only data bits 7:0 are compared against command codes. Bits 15:8 of command writes have no effect.
- R13: dqOe is high exactly when chip enable and output enable are both low.
- R14: Reset clears the sequence, ends any busy state and selects array reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 18 | Word address |
| dqIn | input | 16 | Write data |
| dqOut | output | 16 | Read data or busy status |
| dqOe | output | 1 | Output drive enable |

## Verification
The assertions take for granted that the bus is synchronous to clk and that each strobe level lasts at least one clock. They also assume that a write and a read with output enable low never overlap, except in the deliberate inhibit case. The stimulus changes every input on the falling edge and leaves one idle cycle after each write and each read, so every access ends in a clean edge. After each operation it waits longer than the busy window, except where a test sets out to probe the busy window itself.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PROG, S_E3, S_E4, S_E5
  } seqSt_t;

  typedef enum logic [1:0] {M_ARRAY, M_ID, M_CFI} rdMode_t;

  typedef enum logic [1:0] {K_PROG, K_SECT, K_BLK, K_CHIP} opKind_t;

  // strobes from the control path to the storage datapath
  typedef struct packed {
    logic progWr;    // apply a clear-only program at the captured address
    logic sweepClr;  // restart the erase sweep pointer
    logic sweepWr;   // erase sweep step enable
    logic togClr;    // status toggle back to 0
    logic togFlip;   // status toggle inverts
  } ctlStb_t;

  localparam logic [7:0] C_UNLK1 = 8'hAA;
  localparam logic [7:0] C_UNLK2 = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_ID    = 8'h90;
  localparam logic [7:0] C_QUERY = 8'h98;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_BLK   = 8'h50;

endpackage

// File: rtl/flashBusSampler.sv
module flashBusSampler #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic              wrDone,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              rdEnd
);

  logic wrActive, wrActQ, rdActive, rdActQ;

  assign wrActive = !ceN && !weN && oeN;
  assign rdActive = !ceN && !oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ <= 1'b0;
      rdActQ <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrActQ <= wrActive;
      rdActQ <= rdActive;
      if (wrActive && !wrActQ) wrAddr <= addr;  // later strobe falling
      if (wrActive) wrData <= dqIn;             // last value before release
    end
  end

  // a cycle only counts if it closed with output enable still high
  assign wrDone = wrActQ && !wrActive && oeN;
  assign rdEnd  = rdActQ && !rdActive;

endmodule

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flcmd_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_LEN = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrDone,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrCmd,
  input  logic              rdEnd,
  output ctlStb_t           stb,
  output logic              busy,
  output rdMode_t           mode,
  output opKind_t           kind,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic              tgtPoll
);

  localparam int MAX_LEN = (ERASE_LEN > PROG_CYC) ? ERASE_LEN : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [ADDR_W-1:0] A_5555 = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] A_2AAA = ADDR_W'(16'h2AAA);
  localparam logic [ADDR_W-1:0] A_QRY  = ADDR_W'(16'h0055);

  seqSt_t st, nextSt;
  rdMode_t nextMode;
  opKind_t opKind;
  logic startOp;
  logic [CNT_W-1:0] cnt;
  logic isU1, isU2, at5555;

  assign at5555 = (wrAddr == A_5555);
  assign isU1   = at5555 && (wrCmd == C_UNLK1);
  assign isU2   = (wrAddr == A_2AAA) && (wrCmd == C_UNLK2);

  always_comb begin
    nextSt   = st;
    nextMode = mode;
    startOp  = 1'b0;
    opKind   = K_PROG;
    if (wrDone && !busy) begin
      // fallback for every mismatch: sequence dropped, array reads
      nextSt   = S_IDLE;
      nextMode = M_ARRAY;
      case (st)
        S_IDLE: begin
          if (isU1) begin
            nextSt = S_U1; nextMode = mode;
          end else if (wrAddr == A_QRY && wrCmd == C_QUERY) begin
            nextMode = M_CFI;
          end
        end
        S_U1: if (isU2) begin nextSt = S_U2; nextMode = mode; end
        S_U2: begin
          if (at5555) begin
            case (wrCmd)
              C_PROG:  begin nextSt = S_PROG; nextMode = mode; end
              C_ERASE: begin nextSt = S_E3;   nextMode = mode; end
              C_ID:    nextMode = M_ID;
              C_QUERY: nextMode = M_CFI;
              default: ;  // exit code and unknown codes: array reads
            endcase
          end
        end
        S_PROG: begin startOp = 1'b1; opKind = K_PROG; end
        S_E3: if (isU1) begin nextSt = S_E4; nextMode = mode; end
        S_E4: if (isU2) begin nextSt = S_E5; nextMode = mode; end
        S_E5: begin
          if (wrCmd == C_CHIP && at5555) begin startOp = 1'b1; opKind = K_CHIP; end
          else if (wrCmd == C_SECT)      begin startOp = 1'b1; opKind = K_SECT; end
          else if (wrCmd == C_BLK)       begin startOp = 1'b1; opKind = K_BLK;  end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= S_IDLE;
      mode    <= M_ARRAY;
      busy    <= 1'b0;
      cnt     <= '0;
      kind    <= K_PROG;
      tgtAddr <= '0;
      tgtPoll <= 1'b0;
    end else begin
      st   <= nextSt;
      mode <= nextMode;
      if (startOp) begin
        busy    <= 1'b1;
        cnt     <= (opKind == K_PROG) ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_LEN);
        kind    <= opKind;
        tgtAddr <= wrAddr;
        tgtPoll <= ~wrCmd[7];
      end else if (busy) begin
        if (cnt == CNT_W'(1)) busy <= 1'b0;
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.progWr   = startOp && (opKind == K_PROG);
    stb.sweepClr = startOp && (opKind != K_PROG);
    stb.sweepWr  = busy && (kind != K_PROG);
    stb.togClr   = startOp;
    stb.togFlip  = rdEnd && busy;
  end

  // R5: a write seen while busy leaves sequence and read mode untouched
  p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy && wrDone |=> (st == $past(st)) && (mode == $past(mode)));

  // R3: busy only ever begins on the edge that closes a write
  p_start_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrDone));

  // R9: a bad second unlock step drops back to array reads
  p_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrDone && !busy && (st == S_U1) && (wrCmd != C_UNLK2)
      |=> (st == S_IDLE) && (mode == M_ARRAY));

endmodule

// File: rtl/flashStore.sv
module flashStore
  import flcmd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int ARR_AW  = 12,
  parameter int SECT_AW = 11,
  parameter int BLK_AW  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic              busy,
  input  rdMode_t           mode,
  input  opKind_t           kind,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic              tgtPoll,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ARR_AW;
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_AW;
  localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ARR_AW:0]   sweepPtr;
  logic [ARR_AW-1:0] sweepIdx, wrIdx, rdIdx;
  logic [ADDR_W-1:0] sweepDiff;
  logic sweepLive, regionHit, wrInArr, rdInArr, tog;

  assign wrIdx     = wrAddr[ARR_AW-1:0];
  assign rdIdx     = rdAddr[ARR_AW-1:0];
  assign wrInArr   = (wrAddr[ADDR_W-1:ARR_AW] == '0);
  assign rdInArr   = (rdAddr[ADDR_W-1:ARR_AW] == '0);
  assign sweepIdx  = sweepPtr[ARR_AW-1:0];
  assign sweepLive = stb.sweepWr && !sweepPtr[ARR_AW];
  assign sweepDiff = ADDR_W'(sweepIdx) ^ tgtAddr;

  always_comb begin
    case (kind)
      K_CHIP:  regionHit = 1'b1;
      K_SECT:  regionHit = ((sweepDiff & SECT_MASK) == '0);
      K_BLK:   regionHit = ((sweepDiff & BLK_MASK) == '0);
      default: regionHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweepPtr <= '0;
      tog      <= 1'b0;
    end else begin
      if (stb.sweepClr)  sweepPtr <= '0;
      else if (sweepLive) sweepPtr <= sweepPtr + 1'b1;
      if (stb.togClr)       tog <= 1'b0;
      else if (stb.togFlip) tog <= ~tog;
    end
  end

  // nonvolatile contents: no reset
  always_ff @(posedge clk) begin
    if (stb.progWr && wrInArr)        mem[wrIdx]    <= mem[wrIdx] & wrData;
    else if (sweepLive && regionHit)  mem[sweepIdx] <= ONES;
  end

  always_comb begin
    rdData = '0;
    if (busy) begin
      rdData[7] = (kind == K_PROG) ? tgtPoll : 1'b0;
      rdData[6] = tog;
    end else begin
      case (mode)
        M_ID: begin
          if (rdAddr == ADDR_W'(0))      rdData = DATA_W'(16'h00BF);
          else if (rdAddr == ADDR_W'(1)) rdData = DATA_W'(16'h272E);
        end
        M_CFI: begin
          if (rdAddr == ADDR_W'(16'h10))      rdData = DATA_W'(16'h0051);
          else if (rdAddr == ADDR_W'(16'h11)) rdData = DATA_W'(16'h0052);
          else if (rdAddr == ADDR_W'(16'h12)) rdData = DATA_W'(16'h0059);
        end
        default: rdData = rdInArr ? mem[rdIdx] : ONES;
      endcase
    end
  end

  // R2: a program never sets a bit that was clear
  p_clear_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.progWr && wrInArr |=> (mem[$past(wrIdx)] & ~$past(mem[wrIdx])) == '0);

  // R4: each finished read during busy inverts the toggle bit
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.togFlip && !stb.togClr |=> tog != $past(tog));

endmodule

// File: rtl/flashCmdFront.sv
module flashCmdFront
  import flcmd_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int ARR_AW    = 12,
  parameter int SECT_AW   = 11,
  parameter int BLK_AW    = 15,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  // the erase sweep visits every stored word once, so busy covers it
  localparam int SWEEP_LEN = (1 << ARR_AW) + 1;
  localparam int ERASE_LEN = (ERASE_CYC > SWEEP_LEN) ? ERASE_CYC : SWEEP_LEN;

  logic              wrDone, rdEnd, busy, tgtPoll;
  logic [ADDR_W-1:0] wrAddr, tgtAddr;
  logic [DATA_W-1:0] wrData;
  ctlStb_t           stb;
  rdMode_t           mode;
  opKind_t           kind;

  flashBusSampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uBus (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .wrDone(wrDone), .wrAddr(wrAddr),
    .wrData(wrData), .rdEnd(rdEnd)
  );

  flashCmdCtrl #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_LEN(ERASE_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .wrDone(wrDone), .wrAddr(wrAddr),
    .wrCmd(wrData[7:0]), .rdEnd(rdEnd), .stb(stb), .busy(busy),
    .mode(mode), .kind(kind), .tgtAddr(tgtAddr), .tgtPoll(tgtPoll)
  );

  flashStore #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_AW(ARR_AW),
               .SECT_AW(SECT_AW), .BLK_AW(BLK_AW)) uStore (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .mode(mode),
    .kind(kind), .tgtAddr(tgtAddr), .tgtPoll(tgtPoll), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(addr), .rdData(dqOut)
  );

  assign dqOe = !ceN && !oeN;

endmodule

// File: tb/sim_flashCmdFront.sv
module sim_flashCmdFront;

  localparam int PW = 40;
  localparam int EW = 4200;
  localparam int NV = 95;
  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OD = 2'd2;

  localparam logic [35:0] VEC [NV] = '{
    // 0..8 chip erase
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h0080},
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h0010},
    {OD,18'h0,16'd4200}, {OR,18'h00000,16'hFFFF}, {OR,18'h00FFF,16'hFFFF},
    // 9..26 programs
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h00A0},
    {OW,18'h00010,16'h1234}, {OD,18'h0,16'd50}, {OR,18'h00010,16'h1234},
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h00A0},
    {OW,18'h00010,16'hFF0F}, {OD,18'h0,16'd50}, {OR,18'h00010,16'h1204},
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h00A0},
    {OW,18'h00810,16'h00FF}, {OD,18'h0,16'd50}, {OR,18'h00810,16'h00FF},
    // 27..32 upper byte garbage in command writes
    {OW,18'h05555,16'h12AA}, {OW,18'h02AAA,16'hFF55}, {OW,18'h05555,16'h33A0},
    {OW,18'h00020,16'h5A5A}, {OD,18'h0,16'd50}, {OR,18'h00020,16'h5A5A},
    // 33..41 sector erase of sector 1
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h0080},
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h00900,16'h0030},
    {OD,18'h0,16'd4200}, {OR,18'h00810,16'hFFFF}, {OR,18'h00010,16'h1204},
    // 42..51 ID mode
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h0090},
    {OR,18'h00000,16'h00BF}, {OR,18'h00001,16'h272E}, {OR,18'h00002,16'h0000},
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h00F0},
    {OR,18'h00010,16'h1204},
    // 52..66 query mode, both entries
    {OW,18'h00055,16'h0098}, {OR,18'h00010,16'h0051}, {OR,18'h00011,16'h0052},
    {OR,18'h00012,16'h0059}, {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055},
    {OW,18'h05555,16'h00F0}, {OR,18'h00010,16'h1204}, {OW,18'h05555,16'h00AA},
    {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h0098}, {OR,18'h00012,16'h0059},
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h00F0},
    // 67..77 aborts
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0066}, {OW,18'h05555,16'h00A0},
    {OW,18'h00020,16'h0000}, {OD,18'h0,16'd50}, {OR,18'h00020,16'h5A5A},
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h0090},
    {OW,18'h01234,16'h00AA}, {OR,18'h00000,16'hFFFF},
    // 78..94 block erases
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h0080},
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h08000,16'h0050},
    {OD,18'h0,16'd4200}, {OR,18'h00010,16'h1204},
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h05555,16'h0080},
    {OW,18'h05555,16'h00AA}, {OW,18'h02AAA,16'h0055}, {OW,18'h00123,16'h0050},
    {OD,18'h0,16'd4200}, {OR,18'h00010,16'hFFFF}, {OR,18'h00020,16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rstN, ceN, weN, oeN, dqOe;
  logic [17:0] addr;
  logic [15:0] dqIn, dqOut, rd, s1, s2;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flashCmdFront #(.PROG_CYC(PW), .ERASE_CYC(100)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  function automatic string tagFor(input int i);
    if (i < 9)  return "R8";
    if (i < 27) return "R2";
    if (i < 33) return "R12";
    if (i < 42) return "R6";
    if (i < 52) return "R10";
    if (i < 67) return "R11";
    if (i < 78) return "R9";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [15:0] got,
                       input logic [15:0] exp, input logic [15:0] mask);
    nChecks++;
    if ((got & mask) !== (exp & mask)) begin
      nFail++;
      $display("FAIL %s: got %h expected %h (mask %h)", tag, got, exp, mask);
    end
  endtask

  task automatic doWrite(input logic [17:0] a, input logic [15:0] d);
    addr = a; dqIn = d; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doRead(input logic [17:0] a, output logic [15:0] d);
    addr = a; weN = 1'b1; ceN = 1'b0; oeN = 1'b0;
    #1 d = dqOut;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock3(input logic [15:0] code);
    doWrite(18'h05555, 16'h00AA);
    doWrite(18'h02AAA, 16'h0055);
    doWrite(18'h05555, code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL R3: got no completion expected finish before watchdog");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1; addr = '0; dqIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R14", {15'd0, dqOe}, 16'h0000, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][35:34])
        OW: doWrite(VEC[i][33:16], VEC[i][15:0]);
        OR: begin
          doRead(VEC[i][33:16], rd);
          check(tagFor(i), rd, VEC[i][15:0], 16'hFFFF);
        end
        default: repeat (int'(VEC[i][15:0])) @(negedge clk);
      endcase
    end

    // R3: busy through the last counted cycle, data right after
    unlock3(16'h00A0);
    doWrite(18'h00040, 16'h0080);
    repeat (PW - 1) @(negedge clk);
    doRead(18'h00040, rd);
    check("R3", rd, 16'h0000, 16'hFFBF);
    doRead(18'h00040, rd);
    check("R3", rd, 16'h0080, 16'hFFFF);

    // R4 polling and toggling, R5 writes ignored while busy
    unlock3(16'h00A0);
    doWrite(18'h00050, 16'h0000);
    doRead(18'h00050, s1);
    doRead(18'h00050, s2);
    check("R4", s1, 16'h0080, 16'hFFBF);
    check("R4", {15'd0, s1[6] ^ s2[6]}, 16'h0001, 16'hFFFF);
    unlock3(16'h0090);
    repeat (PW + 10) @(negedge clk);
    doRead(18'h00000, rd);
    check("R5", rd, 16'hFFFF, 16'hFFFF);
    doRead(18'h00050, rd);
    check("R2", rd, 16'h0000, 16'hFFFF);

    // R1: output enable low during a write discards it
    unlock3(16'h00A0);
    addr = 18'h00030; dqIn = 16'h0000; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    oeN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    @(negedge clk);
    repeat (PW + 5) @(negedge clk);
    doRead(18'h00030, rd);
    check("R1", rd, 16'hFFFF, 16'hFFFF);
    // R1: first-cycle address, last-cycle data
    addr = 18'h00030; dqIn = 16'hFFFF; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    addr = 18'h00031; dqIn = 16'h0F0F;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    repeat (PW + 5) @(negedge clk);
    doRead(18'h00030, rd);
    check("R1", rd, 16'h0F0F, 16'hFFFF);
    doRead(18'h00031, rd);
    check("R1", rd, 16'hFFFF, 16'hFFFF);

    // R4 erase status, R8 chip erase result
    unlock3(16'h0080);
    doWrite(18'h05555, 16'h00AA);
    doWrite(18'h02AAA, 16'h0055);
    doWrite(18'h05555, 16'h0010);
    doRead(18'h00000, rd);
    check("R4", rd, 16'h0000, 16'hFFBF);
    repeat (EW) @(negedge clk);
    doRead(18'h00030, rd);
    check("R8", rd, 16'hFFFF, 16'hFFFF);

    // R13 output enable decode
    ceN = 1'b1; oeN = 1'b0; #1 check("R13", {15'd0, dqOe}, 16'h0000, 16'hFFFF);
    ceN = 1'b0; oeN = 1'b1; #1 check("R13", {15'd0, dqOe}, 16'h0000, 16'hFFFF);
    ceN = 1'b0; oeN = 1'b0; #1 check("R13", {15'd0, dqOe}, 16'h0001, 16'hFFFF);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);

    // R14: reset leaves ID mode
    unlock3(16'h0090);
    doRead(18'h00000, rd);
    check("R10", rd, 16'h00BF, 16'hFFFF);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doRead(18'h00000, rd);
    check("R14", rd, 16'hFFFF, 16'hFFFF);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule